// File: doc/BRIEF.md
# Save-State Command Sequencer

This block is the host-side master that tells a security coprocessor to save its internal state before the system suspends. A single start pulse sets off a fixed handshake over a byte-wide register bus. The block first makes sure the host owns the coprocessor's locality 0. It then brings the coprocessor's command interface to the ready state and pushes a ten-byte save-state command in burst-sized chunks. It confirms the handshake, sets the command going and collects the ten-byte response header.

Each phase that polls a register has its own cycle-count limit. When a limit runs out, the sequencer stops. It reports an error, and the status code is the last access or status byte it read. On completion it raises `done` for one cycle. The flags and the code stay readable until the next start, and the response header is available as a flat vector.

Top module: `suspend_save_seq`

## Requirements
- R1: The command bytes are written to the data port (address 0x24) in this order: 00 C1 00 00 00 0A 00 00 00 98. Go (0x20 written to status, 0x18) is issued only after all ten bytes have been written.
- R2: At most one of the write strobe and the read strobe is high in any cycle. Read data is taken in the same cycle as the read strobe.
- R3: Locality acquisition starts with a read of the access register (0x00). If bits 7 (valid) and 5 (active) are both set, the request is skipped. Otherwise 0x02 is written there, and the register is polled until both bits are set. If ACC_TMO polls fail, the sequence ends with an error, and the code is the last access byte.
- R4: The status register (0x18) is read next. If bit 6 (command-ready) is clear, 0x40 is written there and the register is polled until bit 6 is set. If RDY_TMO polls fail, the sequence ends with an error.
- R5: The burst count is read as a low byte (0x19) followed by a high byte (0x1A). A zero count is read again. If BURST_TMO reads return zero, the sequence ends with an error, and the code is the last status byte read.
- R6: Every command byte except the last is written in chunks of no more than the burst count. After each chunk, status is polled until bit 7 and bit 3 (data-expect) are both set, with a limit of DATA_TMO polls.
- R7: After the last byte is written, status is polled until bit 7 is set. If bit 3 is still set at that point, the sequence ends with an error, and the code is that status byte. Otherwise go is written.
- R8: On the response side, each burst starts by polling status until bit 7 and bit 4 (data-available) are both set, with a limit of DATA_TMO polls. The burst count is then read, and up to that many bytes are read from 0x24. Exactly ten bytes are read in total. Byte i appears at `resp_bytes[8i+7:8i]`.
- R9: `done` is high for exactly one cycle per accepted start. `error` and `status_code` are valid in that cycle and hold until the next start. On success the code is 0x00.
- R10: A start pulse that arrives while `busy` is high has no effect on the running sequence.
- R11: After reset, the block is idle: `busy`, `done`, `error`, the strobes and `status_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to run the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last run ended in failure |
| status_code | output | 8 | Failing register byte, or 0x00 on success |
| resp_bytes | output | 8*RESP_LEN | Collected response header, byte 0 in the low bits |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid in the read-strobe cycle |

## Verification
The assertions assume the following about the target:
- It returns read data combinationally in the same cycle as the read strobe.
- `start` is a single-cycle pulse.
- Every timeout parameter is at least one.

The stimulus keeps to these. A behavioural register target answers reads at once and applies each write on the clock edge that ends it. The bench drives `start` high for exactly one cycle, with one extra pulse landing mid-run. Per-case latencies and stuck bits inside that target push each poll phase into its timeout.

// File: rtl/ssq_pkg.sv
// Package: shared register offsets, bit masks, state encoding and the fixed
// command contents for the save-state sequencer. Assumes an 8-bit register map.
package ssq_pkg;

    localparam logic [7:0] REG_ACCESS  = 8'h00;
    localparam logic [7:0] REG_STATUS  = 8'h18;
    localparam logic [7:0] REG_BURST_L = 8'h19;
    localparam logic [7:0] REG_BURST_H = 8'h1A;
    localparam logic [7:0] REG_FIFO    = 8'h24;

    localparam logic [7:0] ACC_VALID   = 8'h80;
    localparam logic [7:0] ACC_ACTIVE  = 8'h20;
    localparam logic [7:0] ACC_REQUEST = 8'h02;

    localparam logic [7:0] ST_VALID    = 8'h80;
    localparam logic [7:0] ST_READY    = 8'h40;
    localparam logic [7:0] ST_GO       = 8'h20;
    localparam logic [7:0] ST_AVAIL    = 8'h10;
    localparam logic [7:0] ST_EXPECT   = 8'h08;

    localparam int CMD_LEN = 10;

    typedef enum logic [4:0] {
        S_IDLE, S_ACC_CHK, S_ACC_REQ, S_ACC_POLL,
        S_RDY_CHK, S_RDY_REQ, S_RDY_POLL,
        S_BC_LO, S_BC_HI,
        S_WR_DATA, S_WR_EXP, S_WR_LAST, S_WR_VALID, S_GO,
        S_RD_AVAIL, S_RD_DATA, S_FIN
    } seq_state_t;

    // Returns the save-state command byte at position idx.
    function automatic logic [7:0] cmd_byte(input int idx);
        case (idx)
            1:       return 8'hC1;
            5:       return 8'h0A;
            9:       return 8'h98;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ssq_poll_timer.sv
// Poll-attempt counter: counts failed polls of the current phase and flags
// the attempt that uses up the limit. Assumes limit >= 1 and that the owner
// clears it on entry to each polling phase.
module ssq_poll_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last_try
);

    logic [CNT_W-1:0] cnt_q;

    // Counts failed attempts; clear has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end

    // The current attempt is the last allowed one.
    assign last_try = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

endmodule

// File: rtl/ssq_resp_store.sv
// Response header store: one byte register per position, written by index,
// cleared at the start of each run. Assumes idx < N whenever we is high.
module ssq_resp_store #(
    parameter int N     = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [8*N-1:0]   bytes_o
);

    for (genvar g = 0; g < N; g++) begin : g_byte
        logic [7:0] r_q;
        // Holds response byte g.
        always_ff @(posedge clk) begin
            if (!rst_n)                          r_q <= '0;
            else if (clear)                      r_q <= '0;
            else if (we && idx == IDX_W'(g))     r_q <= din;
        end
        assign bytes_o[8*g +: 8] = r_q;
    end

endmodule

// File: rtl/suspend_save_seq.sv
// Save-state sequencer top: on start it acquires locality 0, readies the
// command interface, streams the fixed command in bursts, issues go and reads
// the response header. Assumes read data is valid in the read-strobe cycle.
module suspend_save_seq
    import ssq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RESP_LEN  = 10,
    parameter int ACC_TMO   = 16,
    parameter int RDY_TMO   = 16,
    parameter int BURST_TMO = 16,
    parameter int DATA_TMO  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  busy,
    output logic                  done,
    output logic                  error,
    output logic [7:0]            status_code,
    output logic [8*RESP_LEN-1:0] resp_bytes,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [7:0]            bus_wdata,
    output logic                  bus_wr,
    output logic                  bus_rd,
    input  logic [7:0]            bus_rdata
);

    localparam int MAX_AB  = (ACC_TMO > RDY_TMO) ? ACC_TMO : RDY_TMO;
    localparam int MAX_CD  = (BURST_TMO > DATA_TMO) ? BURST_TMO : DATA_TMO;
    localparam int MAX_TMO = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TMO_W   = $clog2(MAX_TMO + 1);
    localparam int LEN_MAX = (CMD_LEN > RESP_LEN) ? CMD_LEN : RESP_LEN;
    localparam int IDX_W   = $clog2(LEN_MAX + 1);

    localparam logic [ADDR_W-1:0] A_ACC  = ADDR_W'(REG_ACCESS);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_BCL  = ADDR_W'(REG_BURST_L);
    localparam logic [ADDR_W-1:0] A_BCH  = ADDR_W'(REG_BURST_H);
    localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(REG_FIFO);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
    logic [15:0]      burst_q;
    logic [7:0]       bc_lo_q, last_reg_q, code_q;
    logic             err_q;
    logic             t_clear, t_step, t_last, fail;
    logic [TMO_W-1:0] t_limit;
    logic             acc_ok, rdy_ok, exp_ok, val_ok, avail_ok, tracked_rd;
    logic             launch;

    assign launch   = (state_q == S_IDLE) && start;
    assign acc_ok   = (bus_rdata & (ACC_VALID | ACC_ACTIVE)) == (ACC_VALID | ACC_ACTIVE);
    assign rdy_ok   = (bus_rdata & ST_READY) != 8'h00;
    assign exp_ok   = (bus_rdata & (ST_VALID | ST_EXPECT)) == (ST_VALID | ST_EXPECT);
    assign val_ok   = (bus_rdata & ST_VALID) != 8'h00;
    assign avail_ok = (bus_rdata & (ST_VALID | ST_AVAIL)) == (ST_VALID | ST_AVAIL);
    assign tracked_rd = bus_rd && (bus_addr == A_ACC || bus_addr == A_STS);

    // Drives the register bus from the current state.
    always_comb begin
        bus_addr  = A_STS;
        bus_wdata = 8'h00;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        case (state_q)
            S_ACC_CHK, S_ACC_POLL: begin bus_addr = A_ACC; bus_rd = 1'b1; end
            S_ACC_REQ:  begin bus_addr = A_ACC; bus_wdata = ACC_REQUEST; bus_wr = 1'b1; end
            S_RDY_CHK, S_RDY_POLL, S_WR_EXP, S_WR_VALID, S_RD_AVAIL: bus_rd = 1'b1;
            S_RDY_REQ:  begin bus_wdata = ST_READY; bus_wr = 1'b1; end
            S_BC_LO:    begin bus_addr = A_BCL; bus_rd = 1'b1; end
            S_BC_HI:    begin bus_addr = A_BCH; bus_rd = 1'b1; end
            S_WR_DATA:  begin bus_addr = A_FIFO; bus_wdata = cmd_byte(int'(wr_idx_q)); bus_wr = 1'b1; end
            S_WR_LAST:  begin bus_addr = A_FIFO; bus_wdata = cmd_byte(CMD_LEN - 1); bus_wr = 1'b1; end
            S_GO:       begin bus_wdata = ST_GO; bus_wr = 1'b1; end
            S_RD_DATA:  begin bus_addr = A_FIFO; bus_rd = 1'b1; end
            default: ;
        endcase
    end

    // Selects the poll limit that belongs to the current phase.
    always_comb begin
        case (state_q)
            S_ACC_POLL:       t_limit = TMO_W'(ACC_TMO);
            S_RDY_POLL:       t_limit = TMO_W'(RDY_TMO);
            S_BC_LO, S_BC_HI: t_limit = TMO_W'(BURST_TMO);
            default:          t_limit = TMO_W'(DATA_TMO);
        endcase
    end

    // Next-state logic with timer control and failure detection.
    always_comb begin
        state_d = state_q;
        t_clear = 1'b0;
        t_step  = 1'b0;
        fail    = 1'b0;
        case (state_q)
            S_IDLE:     if (start) state_d = S_ACC_CHK;
            S_ACC_CHK:  state_d = acc_ok ? S_RDY_CHK : S_ACC_REQ;
            S_ACC_REQ:  begin state_d = S_ACC_POLL; t_clear = 1'b1; end
            S_ACC_POLL: if (acc_ok) state_d = S_RDY_CHK;
                        else if (t_last) fail = 1'b1;
                        else t_step = 1'b1;
            S_RDY_CHK:  begin
                            state_d = rdy_ok ? S_BC_LO : S_RDY_REQ;
                            t_clear = 1'b1;
                        end
            S_RDY_REQ:  begin state_d = S_RDY_POLL; t_clear = 1'b1; end
            S_RDY_POLL: if (rdy_ok) begin state_d = S_BC_LO; t_clear = 1'b1; end
                        else if (t_last) fail = 1'b1;
                        else t_step = 1'b1;
            S_BC_LO:    state_d = S_BC_HI;
            S_BC_HI:    if ({bus_rdata, bc_lo_q} != 16'h0000) begin
                            state_d = (rd_idx_q != '0 || state_q == S_BC_HI && rd_phase_q)
                                      ? S_RD_DATA : S_WR_DATA;
                            t_clear = 1'b1;
                        end else if (t_last) fail = 1'b1;
                        else begin state_d = S_BC_LO; t_step = 1'b1; end
            S_WR_DATA:  if (wr_idx_q + 1'b1 == IDX_W'(CMD_LEN - 1) || burst_q == 16'd1) begin
                            state_d = S_WR_EXP;
                            t_clear = 1'b1;
                        end
            S_WR_EXP:   if (exp_ok) begin
                            state_d = (wr_idx_q == IDX_W'(CMD_LEN - 1)) ? S_WR_LAST : S_BC_LO;
                            t_clear = 1'b1;
                        end else if (t_last) fail = 1'b1;
                        else t_step = 1'b1;
            S_WR_LAST:  begin state_d = S_WR_VALID; t_clear = 1'b1; end
            S_WR_VALID: if (val_ok) begin
                            if ((bus_rdata & ST_EXPECT) != 8'h00) fail = 1'b1;
                            else state_d = S_GO;
                        end else if (t_last) fail = 1'b1;
                        else t_step = 1'b1;
            S_GO:       begin state_d = S_RD_AVAIL; t_clear = 1'b1; end
            S_RD_AVAIL: if (avail_ok) begin state_d = S_BC_LO; t_clear = 1'b1; end
                        else if (t_last) fail = 1'b1;
                        else t_step = 1'b1;
            S_RD_DATA:  if (rd_idx_q + 1'b1 == IDX_W'(RESP_LEN)) state_d = S_FIN;
                        else if (burst_q == 16'd1) begin
                            state_d = S_RD_AVAIL;
                            t_clear = 1'b1;
                        end
            S_FIN:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
        if (fail) state_d = S_FIN;
    end

    logic rd_phase_q;

    // Sequencer registers: state, indices, burst budget and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            wr_idx_q   <= '0;
            rd_idx_q   <= '0;
            burst_q    <= '0;
            bc_lo_q    <= '0;
            rd_phase_q <= 1'b0;
            last_reg_q <= '0;
            err_q      <= 1'b0;
            code_q     <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                wr_idx_q   <= '0;
                rd_idx_q   <= '0;
                rd_phase_q <= 1'b0;
                err_q      <= 1'b0;
                code_q     <= '0;
            end
            if (tracked_rd) last_reg_q <= bus_rdata;
            case (state_q)
                S_BC_LO:   bc_lo_q <= bus_rdata;
                S_BC_HI:   if ({bus_rdata, bc_lo_q} != 16'h0000) burst_q <= {bus_rdata, bc_lo_q};
                S_WR_DATA: begin wr_idx_q <= wr_idx_q + 1'b1; burst_q <= burst_q - 16'd1; end
                S_GO:      rd_phase_q <= 1'b1;
                S_RD_DATA: begin rd_idx_q <= rd_idx_q + 1'b1; burst_q <= burst_q - 16'd1; end
                default: ;
            endcase
            if (fail) begin
                err_q  <= 1'b1;
                code_q <= tracked_rd ? bus_rdata : last_reg_q;
            end
        end
    end

    ssq_poll_timer #(.CNT_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (t_clear),
        .step     (t_step),
        .limit    (t_limit),
        .last_try (t_last)
    );

    ssq_resp_store #(.N(RESP_LEN), .IDX_W(IDX_W)) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .we      (state_q == S_RD_DATA),
        .idx     (rd_idx_q),
        .din     (bus_rdata),
        .bytes_o (resp_bytes)
    );

    assign busy        = (state_q != S_IDLE);
    assign done        = (state_q == S_FIN);
    assign error       = err_q;
    assign status_code = code_q;

    // R2: never both strobes in one cycle.
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R9: done lasts exactly one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a new error only ever appears together with done.
    a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);

    // R10: a start while a run is in progress does not end the run.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R8: a successful finish has collected the full response header.
    a_r8_full_response: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> rd_idx_q == IDX_W'(RESP_LEN));

    // R1: go is written only after every command byte before the last went out.
    a_r1_go_after_command: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STS && bus_wdata == ST_GO) |-> wr_idx_q == IDX_W'(CMD_LEN - 1));

endmodule

// File: tb/sim_suspend_save_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural register target plus a monitor that compares every
// bus cycle against the expected command stream and burst budgets.
module sim_suspend_save_seq;

    localparam int NRESP = 10;
    localparam int T_ACC = 6, T_RDY = 6, T_BURST = 5, T_DATA = 20;
    localparam int NEVER = 100000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, error;
    logic [7:0] status_code, bus_wdata, bus_rdata;
    logic [8*NRESP-1:0] resp_bytes;
    logic [7:0] bus_addr;
    logic bus_wr, bus_rd;

    always #2.5 clk = ~clk;

    suspend_save_seq #(.ADDR_W(8), .RESP_LEN(NRESP), .ACC_TMO(T_ACC), .RDY_TMO(T_RDY),
                       .BURST_TMO(T_BURST), .DATA_TMO(T_DATA)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
        .status_code(status_code), .resp_bytes(resp_bytes), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

    int n_chk = 0, n_fail = 0, cycles = 0;
    byte unsigned exp_cmd[10] = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h98};

    function automatic logic [7:0] resp_fn(input int i);
        return 8'(8'h3C + i * 17);
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- target configuration and state ----------------
    int cfg_active0, cfg_acc_lat, cfg_ready0, cfg_rdy_lat, cfg_burst, cfg_zero;
    int cfg_expect_len, cfg_resp_lat, cfg_resp_burst;
    logic dev_init = 1'b0, mon_clear = 1'b0;
    int d_active, d_acc_req, d_acc_cnt, d_ready, d_rdy_req, d_rdy_cnt, d_zero;
    int d_rx, d_go, d_go_cnt, d_tx;
    int burst_now, avail, expect_b;
    logic [7:0] sts_byte;

    always_comb begin
        burst_now = (d_zero > 0) ? 0 : (d_go != 0 ? cfg_resp_burst : cfg_burst);
        avail     = (d_go != 0 && d_go_cnt == 0 && d_tx < NRESP) ? 1 : 0;
        expect_b  = (d_rx >= 1 && d_rx < cfg_expect_len) ? 1 : 0;
        sts_byte  = 8'h80 | (d_ready != 0 ? 8'h40 : 8'h00) | (avail != 0 ? 8'h10 : 8'h00)
                  | (expect_b != 0 ? 8'h08 : 8'h00);
        case (bus_addr)
            8'h00:   bus_rdata = 8'h80 | (d_active != 0 ? 8'h20 : 8'h00);
            8'h18:   bus_rdata = sts_byte;
            8'h19:   bus_rdata = 8'(burst_now);
            8'h1A:   bus_rdata = 8'(burst_now >> 8);
            8'h24:   bus_rdata = resp_fn(d_tx);
            default: bus_rdata = 8'hFF;
        endcase
    end

    // Target register behaviour, applied at the edge that ends each access.
    always @(posedge clk) begin
        if (dev_init) begin
            d_active <= cfg_active0; d_acc_req <= 0; d_acc_cnt <= 0;
            d_ready <= cfg_ready0; d_rdy_req <= 0; d_rdy_cnt <= 0; d_zero <= cfg_zero;
            d_rx <= 0; d_go <= 0; d_go_cnt <= 0; d_tx <= 0;
        end else begin
            if (d_acc_req != 0 && d_active == 0) begin
                if (d_acc_cnt == 0) d_active <= 1; else d_acc_cnt <= d_acc_cnt - 1;
            end
            if (d_rdy_req != 0 && d_ready == 0) begin
                if (d_rdy_cnt == 0) d_ready <= 1; else d_rdy_cnt <= d_rdy_cnt - 1;
            end
            if (d_go != 0 && d_go_cnt > 0) d_go_cnt <= d_go_cnt - 1;
            if (bus_wr && bus_addr == 8'h00 && bus_wdata == 8'h02) begin
                d_acc_req <= 1; d_acc_cnt <= cfg_acc_lat;
            end
            if (bus_wr && bus_addr == 8'h18 && bus_wdata == 8'h40) begin
                d_rdy_req <= 1; d_rdy_cnt <= cfg_rdy_lat;
            end
            if (bus_wr && bus_addr == 8'h18 && bus_wdata == 8'h20) begin
                d_go <= 1; d_go_cnt <= cfg_resp_lat;
            end
            if (bus_wr && bus_addr == 8'h24) begin
                d_rx <= d_rx + 1; d_ready <= 0; d_rdy_req <= 0;
            end
            if (bus_rd && bus_addr == 8'h1A && d_zero > 0) d_zero <= d_zero - 1;
            if (bus_rd && bus_addr == 8'h24) d_tx <= d_tx + 1;
        end
    end

    // ---------------- monitor: compared on every clock ----------------
    int m_wcount, m_chunk, m_burst, m_lo, m_rchunk, m_rcount, m_bad_order, m_bad_chunk;
    int m_two, m_done_cnt, m_after_done, m_req_seen, m_acc_polls, m_go_cnt, m_go_early;

    always @(negedge clk) begin
        cycles++;
        if (mon_clear) begin
            m_wcount = 0; m_chunk = 0; m_burst = 0; m_lo = 0; m_rchunk = 0; m_rcount = 0;
            m_bad_order = 0; m_bad_chunk = 0; m_two = 0; m_done_cnt = 0; m_after_done = 0;
            m_req_seen = 0; m_acc_polls = 0; m_go_cnt = 0; m_go_early = 0;
        end else if (rst_n) begin
            if (m_done_cnt > 0 && (bus_wr || bus_rd)) m_after_done++;
            if (bus_wr && bus_rd) m_two++;
            if (bus_rd && bus_addr == 8'h19) m_lo = int'(bus_rdata);
            if (bus_rd && bus_addr == 8'h1A) begin
                m_burst = (int'(bus_rdata) << 8) | m_lo; m_chunk = 0; m_rchunk = 0;
            end
            if (bus_rd && bus_addr == 8'h18) m_chunk = 0;
            if (bus_wr && bus_addr == 8'h24) begin
                if (m_wcount >= 10 || bus_wdata != exp_cmd[m_wcount]) m_bad_order++;
                if (m_wcount < 9) begin
                    m_chunk++;
                    if (m_chunk > m_burst) m_bad_chunk++;
                end
                m_wcount++;
            end
            if (bus_rd && bus_addr == 8'h24) begin
                m_rchunk++; m_rcount++;
                if (m_rchunk > m_burst) m_bad_chunk++;
            end
            if (bus_rd && bus_addr == 8'h00 && m_req_seen != 0) m_acc_polls++;
            if (bus_wr && bus_addr == 8'h00 && bus_wdata == 8'h02) m_req_seen = 1;
            if (bus_wr && bus_addr == 8'h18 && bus_wdata == 8'h20) begin
                m_go_cnt++;
                if (m_wcount != 10) m_go_early++;
            end
            if (done) m_done_cnt++;
        end
    end

    // ---------------- one scenario ----------------
    task automatic run_case(input string tag, input bit extra_start, input bit exp_err,
                            input int exp_code, input int exp_w, input int exp_go,
                            input int exp_polls, input int exp_reads);
        bit seen = 0;
        logic err_s;
        logic [7:0] code_s;
        logic [8*NRESP-1:0] resp_s;
        @(posedge clk); #1; mon_clear = 1'b1; dev_init = 1'b1;
        @(posedge clk); #1; mon_clear = 1'b0; dev_init = 1'b0;
        start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        if (extra_start) begin
            for (int i = 0; i < 10; i++) begin @(posedge clk); #1; end
            start = 1'b1;
            @(posedge clk); #1; start = 1'b0;
        end
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(posedge clk); #1;
            if (done) seen = 1;
        end
        err_s = error; code_s = status_code; resp_s = resp_bytes;
        check({tag, " R9 done reached"}, seen, int'(seen), 1);
        check({tag, " R9 error flag"}, err_s == exp_err, int'(err_s), int'(exp_err));
        check({tag, " R9 status code"}, code_s == 8'(exp_code), int'(code_s), exp_code);
        for (int i = 0; i < 6; i++) begin @(posedge clk); #1; end
        check({tag, " R9 single done"}, m_done_cnt == 1, m_done_cnt, 1);
        check({tag, " R9 result held"}, error == err_s && status_code == code_s,
              int'(status_code), int'(code_s));
        check({tag, " R10 idle after run"}, !busy && m_after_done == 0, m_after_done, 0);
        check({tag, " R2 one strobe"}, m_two == 0, m_two, 0);
        check({tag, " R1 command order"}, m_bad_order == 0 && m_wcount == exp_w, m_wcount, exp_w);
        check({tag, " R6 burst limit"}, m_bad_chunk == 0, m_bad_chunk, 0);
        check({tag, " R7 go count"}, m_go_cnt == exp_go && m_go_early == 0, m_go_cnt, exp_go);
        check({tag, " R8 response reads"}, m_rcount == exp_reads, m_rcount, exp_reads);
        if (exp_polls >= 0)
            check({tag, " R3 access polls"}, m_acc_polls == exp_polls, m_acc_polls, exp_polls);
        if (!exp_err)
            for (int i = 0; i < NRESP; i++)
                check({tag, " R8 response byte"}, resp_s[8*i +: 8] == resp_fn(i),
                      int'(resp_s[8*i +: 8]), int'(resp_fn(i)));
    endtask

    task automatic set_cfg(input int act0, input int acc_lat, input int rdy0, input int rdy_lat,
                           input int burst, input int zero, input int exp_len,
                           input int resp_lat, input int resp_burst);
        cfg_active0 = act0; cfg_acc_lat = acc_lat; cfg_ready0 = rdy0; cfg_rdy_lat = rdy_lat;
        cfg_burst = burst; cfg_zero = zero; cfg_expect_len = exp_len;
        cfg_resp_lat = resp_lat; cfg_resp_burst = resp_burst;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        wait (cycles > 150000);
        check("R9 watchdog", 1'b0, cycles, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        set_cfg(1, 0, 1, 0, 4, 0, 10, 3, 4);
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset outputs", !busy && !done && !error && status_code == 8'h00,
              int'({busy, done, error}), 0);
        check("R11 reset strobes", !bus_wr && !bus_rd, int'({bus_wr, bus_rd}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 R8: owner already active, ready, bursts of four
        set_cfg(1, 0, 1, 0, 4, 0, 10, 3, 4);
        run_case("normal", 0, 0, 0, 10, 1, 0, 10);
        // R3 R4 R5 R10: request needed, ready requested, zero bursts first, bursts of one
        set_cfg(0, 3, 0, 2, 1, 2, 10, 5, 3);
        run_case("handshake", 1, 0, 0, 10, 1, -1, 10);
        // R5: burst count carried only in the high byte
        set_cfg(1, 0, 1, 0, 256, 0, 10, 0, 256);
        run_case("wide_burst", 0, 0, 0, 10, 1, 0, 10);
        // R3: locality never granted
        set_cfg(0, NEVER, 1, 0, 4, 0, 10, 0, 4);
        run_case("acc_timeout", 0, 1, 8'h80, 0, 0, T_ACC, 0);
        // R4: command-ready never set
        set_cfg(1, 0, 0, NEVER, 4, 0, 10, 0, 4);
        run_case("rdy_timeout", 0, 1, 8'h80, 0, 0, 0, 0);
        // R5: burst count stays zero, code is last status byte
        set_cfg(1, 0, 1, 0, 4, NEVER, 10, 0, 4);
        run_case("burst_timeout", 0, 1, 8'hC0, 0, 0, 0, 0);
        // R7: data-expect still set after the last byte
        set_cfg(1, 0, 1, 0, 3, 0, 11, 0, 4);
        run_case("expect_stuck", 0, 1, 8'h88, 10, 0, 0, 0);
        // R8: response never becomes available
        set_cfg(1, 0, 1, 0, 5, 0, 10, NEVER, 4);
        run_case("resp_timeout", 0, 1, 8'h80, 10, 1, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule